// File: doc/BRIEF.md
# Hit-Under-Miss Data Cache Controller with Snoop Retry

This block is the level-one data cache controller of one processor on a shared snooping bus. It holds a small direct-mapped array of one-word lines with valid and dirty bits. When an access misses, the controller posts one bus request and keeps serving later accesses that hit. Reordering those hits ahead of the older miss would let other processors see this processor's accesses out of program order.

To keep sequential consistency, the controller records whether any hit has completed while the miss is pending. From that point until the fill is written, it asks for a retry on every foreign bus transaction. No other processor can then observe the state in which the younger hits are visible but the older miss is not. If no hit has completed under the miss, foreign traffic passes untouched.

On the CPU side, requests use a valid/ready handshake and arrive in program order. Load data returns with a one-cycle pulse on `rsp_valid`. On the bus side the controller raises a request, waits for a grant, and accepts the fill. When the victim line is dirty, its address and data travel with the request. A grant that another agent retries is followed by a fixed quiet period before the controller requests again.

Top module: `hum_cache`

## Requirements
- R1: After reset, no line is valid, `cpu_ready` is 1, and `rsp_valid`, `bus_req`, `bus_wb` and `snp_retry` are all 0.
- R2: A load (`cpu_we`=0) that hits is accepted at once and returns the stored word with `rsp_valid` high in the next cycle. A store (`cpu_we`=1) that hits writes the word, marks the line dirty and gives no response.
- R3: While a miss is pending, any further access that misses holds `cpu_ready` at 0. Only one miss is outstanding at a time.
- R4: An accepted miss raises `bus_req` in the next cycle. `bus_req` holds until a cycle with `bus_gnt`. After an unretried grant, the first cycle with `bus_fill_valid` completes the miss.
- R5: While a miss is pending, a hit is accepted only if both of these hold:
  - its index differs from the pending line's index (index = low `IDX_W` address bits);
  - it is a store, or the pending miss is itself a store.

  Otherwise `cpu_ready` is 0. This keeps load responses in request order.
- R6: Once a hit has been accepted while a miss is pending, `snp_retry` equals `snp_valid` until the fill is written.
- R7: With no miss pending, or with a pending miss under which no hit has been accepted, `snp_retry` stays 0. Writing the fill clears the hit-under condition.
- R8: A grant that arrives together with `bus_retry_in` drops `bus_req` for exactly `BACKOFF` (default 2) cycles, then `bus_req` rises again for the same line.
- R9: When the victim line at the missing index is valid and dirty, the request shows `bus_wb`=1, `bus_wb_addr` = {victim tag, index} and `bus_wb_data` = the victim word. For a clean or invalid victim, `bus_wb` is 0.
- R10: A load miss returns the fill word with `rsp_valid` one cycle after the fill. A store miss installs its own data in place of the fill word, leaves the line dirty and gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | Request accepted this cycle when high with `cpu_valid` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Load data pulse |
| rsp_data | output | DATA_W | Load data |
| bus_req | output | 1 | Miss request to the bus arbiter |
| bus_gnt | input | 1 | Grant for the request |
| bus_retry_in | input | 1 | Another agent retries the granted request |
| bus_addr | output | ADDR_W | Address being fetched |
| bus_wb | output | 1 | Dirty victim travels with the request |
| bus_wb_addr | output | ADDR_W | Victim address |
| bus_wb_data | output | DATA_W | Victim data |
| bus_fill_valid | input | 1 | Fill word present |
| bus_fill_data | input | DATA_W | Fill word |
| snp_valid | input | 1 | A foreign transaction is on the bus |
| snp_retry | output | 1 | Retry demanded for that transaction |

## Verification
The assertions check four rules on every cycle:
- no miss is accepted while another miss is pending;
- a loaded hit always yields a response in the next cycle;
- retry appears only with a pending miss and never before a hit has been taken under it;
- the request holds until granted, and the quiet period follows a retried grant.

Data values need the bench's scenarios. These cover contents after a store hit, the merging of store-miss data into the fill, and the victim address and data on eviction. The ordering stalls also need the scenarios: a same-index access and a load under a load miss must both be refused while an unrelated store hit is allowed.

// File: rtl/hum_cache.sv
module hum_cache #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 4,
  parameter int BACKOFF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              bus_req,
  input  logic              bus_gnt,
  input  logic              bus_retry_in,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_wb,
  output logic [ADDR_W-1:0] bus_wb_addr,
  output logic [DATA_W-1:0] bus_wb_data,
  input  logic              bus_fill_valid,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic              snp_valid,
  output logic              snp_retry
);
  localparam int LINES  = 1 << IDX_W;
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int BCNT_W = $clog2(BACKOFF + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_BACK, S_WAIT} st_t;

  st_t               st;
  logic [BCNT_W-1:0] bcnt;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];
  logic [LINES-1:0]  vld_q, drt_q;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_wdata;
  logic              pend_we, hu_q;
  logic              rsp_v;
  logic [DATA_W-1:0] rsp_d;
  logic              wb_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic [DATA_W-1:0] wb_data_q;

  logic [IDX_W-1:0] idx, pidx;
  logic [TAG_W-1:0] tg;
  logic hit, miss_pend, accept, fill;

  assign idx       = cpu_addr[IDX_W-1:0];
  assign tg        = cpu_addr[ADDR_W-1:IDX_W];
  assign pidx      = pend_addr[IDX_W-1:0];
  assign hit       = vld_q[idx] && (tag_q[idx] == tg);
  assign miss_pend = (st != S_IDLE);
  assign cpu_ready = !miss_pend || (hit && (idx != pidx) && (cpu_we || pend_we));
  assign accept    = cpu_valid && cpu_ready;
  assign fill      = (st == S_WAIT) && bus_fill_valid;

  assign rsp_valid   = rsp_v;
  assign rsp_data    = rsp_d;
  assign bus_req     = (st == S_REQ);
  assign bus_addr    = pend_addr;
  assign bus_wb      = wb_q;
  assign bus_wb_addr = wb_addr_q;
  assign bus_wb_data = wb_data_q;
  assign snp_retry   = snp_valid && miss_pend && hu_q;

  always_ff @(posedge clk) begin
    if (accept && hit && cpu_we) dat_q[idx] <= cpu_wdata;
    if (fill) begin
      tag_q[pidx] <= pend_addr[ADDR_W-1:IDX_W];
      dat_q[pidx] <= pend_we ? pend_wdata : bus_fill_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      bcnt       <= '0;
      vld_q      <= '0;
      drt_q      <= '0;
      pend_addr  <= '0;
      pend_wdata <= '0;
      pend_we    <= 1'b0;
      hu_q       <= 1'b0;
      rsp_v      <= 1'b0;
      rsp_d      <= '0;
      wb_q       <= 1'b0;
      wb_addr_q  <= '0;
      wb_data_q  <= '0;
    end else begin
      rsp_v <= 1'b0;
      if (accept && hit) begin
        if (cpu_we) drt_q[idx] <= 1'b1;
        else begin
          rsp_v <= 1'b1;
          rsp_d <= dat_q[idx];
        end
        if (miss_pend) hu_q <= 1'b1;
      end
      if (accept && !hit) begin
        pend_addr  <= cpu_addr;
        pend_we    <= cpu_we;
        pend_wdata <= cpu_wdata;
        wb_q       <= vld_q[idx] && drt_q[idx];
        wb_addr_q  <= {tag_q[idx], idx};
        wb_data_q  <= dat_q[idx];
        st         <= S_REQ;
      end
      case (st)
        S_REQ:
          if (bus_gnt) begin
            if (bus_retry_in) begin
              st   <= S_BACK;
              bcnt <= BCNT_W'(BACKOFF - 1);
            end else st <= S_WAIT;
          end
        S_BACK:
          if (bcnt == '0) st <= S_REQ;
          else bcnt <= bcnt - 1'b1;
        S_WAIT:
          if (bus_fill_valid) begin
            st          <= S_IDLE;
            vld_q[pidx] <= 1'b1;
            drt_q[pidx] <= pend_we;
            hu_q        <= 1'b0;
            wb_q        <= 1'b0;
            if (!pend_we) begin
              rsp_v <= 1'b1;
              rsp_d <= bus_fill_data;
            end
          end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hum_cache_chk.sv
module hum_cache_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_valid,
  input logic cpu_ready,
  input logic cpu_we,
  input logic hit,
  input logic miss_pend,
  input logic snp_valid,
  input logic snp_retry,
  input logic bus_req,
  input logic bus_gnt,
  input logic bus_retry_in,
  input logic rsp_valid
);
  AST_LOAD_HIT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_ready && !cpu_we && hit |=> rsp_valid);  // R2

  AST_NO_MISS_UNDER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_pend && cpu_valid && !hit |-> !cpu_ready);  // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req);  // R4

  AST_RETRY_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    miss_pend && snp_valid && $past(miss_pend && cpu_valid && cpu_ready) |-> snp_retry);  // R6

  AST_NO_RETRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_pend |-> !snp_retry);  // R7

  AST_NO_RETRY_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_pend) |-> !snp_retry);  // R7

  AST_BACKOFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_retry_in |=> !bus_req ##1 !bus_req);  // R8
endmodule

bind hum_cache hum_cache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .cpu_we(cpu_we), .hit(hit), .miss_pend(miss_pend), .snp_valid(snp_valid),
  .snp_retry(snp_retry), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_retry_in(bus_retry_in), .rsp_valid(rsp_valid)
);

// File: tb/test_hum_cache.sv
module test_hum_cache;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0, cpu_ready;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        bus_req, bus_gnt = 1'b0, bus_retry_in = 1'b0, bus_wb;
  logic [15:0] bus_addr, bus_wb_addr;
  logic [31:0] bus_wb_data;
  logic        bus_fill_valid = 1'b0;
  logic [31:0] bus_fill_data = '0;
  logic        snp_valid = 1'b0, snp_retry;

  int checks = 0, errors = 0;
  logic        got_v;
  logic [31:0] got_d;

  localparam logic [15:0] A = 16'h0011, A2 = 16'h0021, B = 16'h0022, C = 16'h0033;

  always #5 clk = ~clk;

  hum_cache i_hum_cache (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(logic we, logic [15:0] a, logic [31:0] d);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cpu_valid = 1'b0;
    got_v = rsp_valid; got_d = rsp_data;
  endtask

  task automatic probe_ready(logic we, logic [15:0] a, output logic r);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a;
    #1; r = cpu_ready;
    cpu_valid = 1'b0;
  endtask

  task automatic probe_snoop(output logic r);
    snp_valid = 1'b1; #1; r = snp_retry; snp_valid = 1'b0;
  endtask

  task automatic service(logic [31:0] d);
    for (int i = 0; i < 20 && !bus_req; i++) @(negedge clk);
    bus_gnt = 1'b1;
    @(negedge clk); bus_gnt = 1'b0;
    bus_fill_valid = 1'b1; bus_fill_data = d;
    @(negedge clk); bus_fill_valid = 1'b0;
    got_v = rsp_valid; got_d = rsp_data;
  endtask

  task automatic t_reset();
    check("R1 ready", cpu_ready, 1);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 bus_req", bus_req, 0);
    check("R1 bus_wb", bus_wb, 0);
    check("R1 snp_retry", snp_retry, 0);
  endtask

  task automatic t_load_miss();
    issue(1'b0, A, '0);
    check("R4 req raised", bus_req, 1);
    check("R4 bus_addr", bus_addr, A);
    check("R9 clean victim", bus_wb, 0);
    @(negedge clk);
    check("R4 req held", bus_req, 1);
    service(32'hAAAA1111);
    check("R10 load miss rsp", got_v, 1);
    check("R10 load miss data", got_d, 32'hAAAA1111);
  endtask

  task automatic t_hits();
    issue(1'b0, A, '0);
    check("R2 load hit rsp", got_v, 1);
    check("R2 load hit data", got_d, 32'hAAAA1111);
    check("R2 no bus", bus_req, 0);
    issue(1'b1, A, 32'h5555);
    check("R2 store no rsp", got_v, 0);
    issue(1'b0, A, '0);
    check("R2 store updated", got_d, 32'h5555);
  endtask

  task automatic t_hit_under_store_miss();
    logic r;
    issue(1'b1, B, 32'hBBBB);
    probe_snoop(r);
    check("R7 no retry before hit", r, 0);
    issue(1'b0, A, '0);
    check("R5 load hit under store miss", got_v, 1);
    check("R5 hit data", got_d, 32'h5555);
    probe_snoop(r);
    check("R6 retry after hit", r, 1);
    probe_ready(1'b0, C, r);
    check("R3 second miss stalls", r, 0);
    service(32'hDEAD);
    check("R10 store miss no rsp", got_v, 0);
    probe_snoop(r);
    check("R7 retry cleared by fill", r, 0);
    issue(1'b0, B, '0);
    check("R10 store data merged", got_d, 32'hBBBB);
  endtask

  task automatic t_backoff();
    for (int i = 0; i < 5 && !bus_req; i++) @(negedge clk);
    issue(1'b0, C, '0);
    bus_gnt = 1'b1; bus_retry_in = 1'b1;
    @(negedge clk); bus_gnt = 1'b0; bus_retry_in = 1'b0;
    check("R8 quiet 1", bus_req, 0);
    @(negedge clk);
    check("R8 quiet 2", bus_req, 0);
    @(negedge clk);
    check("R8 re-request", bus_req, 1);
    check("R8 same line", bus_addr, C);
    service(32'hCCCC);
    check("R4 fill after retry", got_d, 32'hCCCC);
  endtask

  task automatic t_evict();
    logic r;
    issue(1'b0, A2, '0);
    check("R9 dirty victim", bus_wb, 1);
    check("R9 victim addr", bus_wb_addr, A);
    check("R9 victim data", bus_wb_data, 32'h5555);
    probe_ready(1'b1, A, r);
    check("R5 same index stalls", r, 0);
    probe_ready(1'b0, C, r);
    check("R5 load under load miss stalls", r, 0);
    probe_ready(1'b1, C, r);
    check("R5 store hit allowed", r, 1);
    service(32'h2222);
    check("R10 evict fill data", got_d, 32'h2222);
    issue(1'b0, A2, '0);
    check("R2 new line hit", got_d, 32'h2222);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_miss();
    t_hits();
    t_hit_under_store_miss();
    t_backoff();
    t_evict();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule